// File: doc/BRIEF.md
# Peripheral Interrupt Collector with NMI Routing

This block takes up to 32 asynchronous peripheral interrupt lines, brings each into the processor clock domain, and holds one pending bit per line. The pending bits drive the interrupt request vector that goes to the CPU-side interrupt controller. Software reaches the block through a plain single-cycle register port. Writing a one to a pending bit flips it: an idle line becomes pending and a pending line is cleared. Writing a zero leaves the bit alone. If the hardware sets a bit in the same cycle that software clears it, the set wins, so no event is lost.

One synchronized peripheral line can also be sent to a registered non-maskable interrupt output. A selector field picks the line. An enable bit turns the routing on or off. Writes to the enable bit take effect only while a key-sequence lock is open. Priority, vectoring and nesting stay in the CPU's own controller.

Top module: `irq_collector`

## Requirements
- R1: After reset, `irq_o` and `nmi_o` are zero and reads of the routing register (0x80), the pending register (0x84) and the key register (0x88) return zero.
- R2: A low-to-high transition on `per_irq_i[n]` sets pending bit n. The bit shows on `irq_o[n]` after the third rising clock edge following the input change. A line that stays high does not set the bit again after software clears it.
- R3: When routing register bit 8 is 0, `nmi_o` is low. When bit 8 is 1, `nmi_o` is a registered copy of the synchronized line chosen by bits 4:0. It rises on the same edge as the matching pending bit and follows a selector change one edge after that write.
- R4: While the lock is closed, a write to the routing register updates bits 4:0 and leaves bit 8 unchanged.
- R5: Writing the low bytes 0x59, 0x16 and 0x88, in that order, to the key register (0x88) opens the lock. Bit 0 of the key register reads 1 while the lock is open and 0 while it is closed.
- R6: A key write carrying the wrong byte for the current step returns the detector to its first step, and that byte is not counted as a first key. Any key write while the lock is open closes it again.
- R7: In a write to the pending register, each data bit set to 1 flips the matching pending bit (0 becomes 1, 1 becomes 0). Each data bit set to 0 leaves its pending bit unchanged. Reads return the pending bits.
- R8: Bits 7:5 and 31:9 of the routing register read as zero regardless of what is written to them.
- R9: If a synchronized rising edge and a software clear reach the same pending bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_addr_i | input | 8 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational; unmapped addresses read zero |
| per_irq_i | input | 32 | Asynchronous peripheral interrupt lines |
| irq_o | output | 32 | Pending interrupt vector to the CPU controller |
| nmi_o | output | 1 | Registered non-maskable interrupt request |

## Verification
Random pending-register writes with random masks, starting from random pending states, cover all four flip cases together. Each readback checks the set, clear and ignore paths on every bit at once. Key-register traffic mixes complete sequences, partial sequences and stray bytes, interleaved with routing writes. This shows whether the enable bit follows the lock state or the raw write data. Directed pulses on a peripheral line confirm the three-edge latency, separate edge-triggered from level-triggered setting, and show which side wins when a set and a clear meet in the same cycle.

// File: rtl/irq_collector_pkg.sv
package irq_collector_pkg;

   // key-sequence detector steps
   typedef enum logic [1:0] {
      LK_IDLE = 2'd0,
      LK_GOT1 = 2'd1,
      LK_GOT2 = 2'd2,
      LK_OPEN = 2'd3
   } lock_st_e;

   localparam int unsigned BUS_DW = 32;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int unsigned WIDTH    = 32,
   parameter int unsigned STAGES   = 2,
   parameter bit          EDGE_SET = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] level_o,
   output logic [WIDTH-1:0] set_o
);

   logic [STAGES-1:0][WIDTH-1:0] pipe_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pipe_q <= '0;
      end else begin
         pipe_q <= {pipe_q[STAGES-2:0], async_i};
      end
   end

   assign level_o = pipe_q[STAGES-1];

   generate
      if (EDGE_SET) begin : g_edge
         logic [WIDTH-1:0] prev_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               prev_q <= '0;
            end else begin
               prev_q <= level_o;
            end
         end
         assign set_o = level_o & ~prev_q;
      end else begin : g_level
         assign set_o = level_o;
      end
   endgenerate

endmodule

// File: rtl/irq_unlock.sv
module irq_unlock
   import irq_collector_pkg::*;
#(
   parameter logic [7:0] KEY0 = 8'h59,
   parameter logic [7:0] KEY1 = 8'h16,
   parameter logic [7:0] KEY2 = 8'h88
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       key_wr_i,
   input  logic [7:0] key_byte_i,
   output logic       open_o
);

   lock_st_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      if (key_wr_i) begin
         unique case (st_q)
            LK_IDLE: st_d = (key_byte_i == KEY0) ? LK_GOT1 : LK_IDLE;
            LK_GOT1: st_d = (key_byte_i == KEY1) ? LK_GOT2 : LK_IDLE;
            LK_GOT2: st_d = (key_byte_i == KEY2) ? LK_OPEN : LK_IDLE;
            LK_OPEN: st_d = LK_IDLE;
            default: st_d = LK_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q <= LK_IDLE;
      end else begin
         st_q <= st_d;
      end
   end

   assign open_o = (st_q == LK_OPEN);

endmodule

// File: rtl/irq_pend.sv
module irq_pend #(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             sw_we_i,
   input  logic [WIDTH-1:0] sw_flip_i,
   input  logic [WIDTH-1:0] hw_set_i,
   output logic [WIDTH-1:0] pend_o
);

   logic [WIDTH-1:0] pend_q;
   logic [WIDTH-1:0] flip;

   assign flip = sw_we_i ? sw_flip_i : '0;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_q <= '0;
      end else begin
         // hardware set is ORed in after the flip so it always wins
         pend_q <= (pend_q ^ flip) | hw_set_i;
      end
   end

   assign pend_o = pend_q;

endmodule

// File: rtl/irq_collector.sv
module irq_collector
   import irq_collector_pkg::*;
#(
   parameter int unsigned N_IRQ       = 32,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          EDGE_SET    = 1'b1,
   parameter logic [ADDR_W-1:0] ROUTE_OFS = 8'h80,
   parameter logic [ADDR_W-1:0] PEND_OFS  = 8'h84,
   parameter logic [ADDR_W-1:0] KEY_OFS   = 8'h88,
   parameter logic [7:0] KEY0 = 8'h59,
   parameter logic [7:0] KEY1 = 8'h16,
   parameter logic [7:0] KEY2 = 8'h88
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              bus_wr_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [31:0]       bus_wdata_i,
   output logic [31:0]       bus_rdata_o,
   input  logic [N_IRQ-1:0]  per_irq_i,
   output logic [N_IRQ-1:0]  irq_o,
   output logic              nmi_o
);

   localparam int unsigned SEL_W  = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;
   localparam int unsigned EN_BIT = 8;

   generate
      if (N_IRQ < 2 || N_IRQ > BUS_DW) begin : g_bad_nirq
         $error("irq_collector: N_IRQ must lie in 2..32");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("irq_collector: SYNC_STAGES must be at least 2");
      end
      if (SEL_W >= EN_BIT) begin : g_bad_sel
         $error("irq_collector: selector overlaps enable bit");
      end
   endgenerate

   logic             wr_route, wr_pend, wr_key;
   logic [N_IRQ-1:0] sync_lvl, hw_rise, pend;
   logic             unlocked;
   logic [SEL_W-1:0] nmi_sel_q;
   logic             nmi_en_q;
   logic             nmi_src;
   logic             nmi_q;

   assign wr_route = bus_wr_i && (bus_addr_i == ROUTE_OFS);
   assign wr_pend  = bus_wr_i && (bus_addr_i == PEND_OFS);
   assign wr_key   = bus_wr_i && (bus_addr_i == KEY_OFS);

   irq_sync #(
      .WIDTH   (N_IRQ),
      .STAGES  (SYNC_STAGES),
      .EDGE_SET(EDGE_SET)
   ) sync_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .async_i(per_irq_i),
      .level_o(sync_lvl),
      .set_o  (hw_rise)
   );

   irq_pend #(
      .WIDTH(N_IRQ)
   ) pend_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sw_we_i  (wr_pend),
      .sw_flip_i(bus_wdata_i[N_IRQ-1:0]),
      .hw_set_i (hw_rise),
      .pend_o   (pend)
   );

   irq_unlock #(
      .KEY0(KEY0),
      .KEY1(KEY1),
      .KEY2(KEY2)
   ) unlock_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .key_wr_i  (wr_key),
      .key_byte_i(bus_wdata_i[7:0]),
      .open_o    (unlocked)
   );

   // routing register: selector always writable, enable only while open
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         nmi_sel_q <= '0;
         nmi_en_q  <= 1'b0;
      end else if (wr_route) begin
         nmi_sel_q <= bus_wdata_i[SEL_W-1:0];
         if (unlocked) begin
            nmi_en_q <= bus_wdata_i[EN_BIT];
         end
      end
   end

   generate
      if (N_IRQ == (1 << SEL_W)) begin : g_sel_full
         assign nmi_src = sync_lvl[nmi_sel_q];
      end else begin : g_sel_guard
         always_comb begin
            nmi_src = 1'b0;
            for (int i = 0; i < N_IRQ; i++) begin
               if (nmi_sel_q == SEL_W'(i)) begin
                  nmi_src = sync_lvl[i];
               end
            end
         end
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         nmi_q <= 1'b0;
      end else begin
         nmi_q <= nmi_en_q & nmi_src;
      end
   end

   always_comb begin
      bus_rdata_o = '0;
      if (bus_addr_i == ROUTE_OFS) begin
         bus_rdata_o[SEL_W-1:0] = nmi_sel_q;
         bus_rdata_o[EN_BIT]    = nmi_en_q;
      end else if (bus_addr_i == PEND_OFS) begin
         bus_rdata_o[N_IRQ-1:0] = pend;
      end else if (bus_addr_i == KEY_OFS) begin
         bus_rdata_o[0] = unlocked;
      end
   end

   assign irq_o = pend;
   assign nmi_o = nmi_q;

endmodule

// File: rtl/irq_collector_chk.sv
module irq_collector_chk #(
   parameter int unsigned N_IRQ  = 32,
   parameter int unsigned ADDR_W = 8,
   parameter logic [ADDR_W-1:0] ROUTE_OFS = 8'h80,
   parameter logic [ADDR_W-1:0] PEND_OFS  = 8'h84,
   parameter logic [ADDR_W-1:0] KEY_OFS   = 8'h88,
   parameter logic [7:0] KEY2 = 8'h88
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              bus_wr_i,
   input logic [ADDR_W-1:0] bus_addr_i,
   input logic [31:0]       bus_wdata_i,
   input logic [31:0]       bus_rdata_o,
   input logic [N_IRQ-1:0]  irq_o,
   input logic              nmi_o,
   input logic [N_IRQ-1:0]  rise_i,
   input logic              nmi_en_i,
   input logic              unlocked_i
);

   localparam int unsigned SEL_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;

   // R3: routing disabled keeps the NMI output low on the next edge
   p_nmi_gated_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !nmi_en_i |=> !nmi_o);

   // R4: the enable bit cannot move while the lock is closed
   p_en_locked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !unlocked_i |=> $stable(nmi_en_i));

   // R5: the lock only opens on a write of the last key byte
   p_open_on_key_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(unlocked_i) |-> $past(bus_wr_i && bus_addr_i == KEY_OFS
                                  && bus_wdata_i[7:0] == KEY2));

   // R6: any key write while open closes the lock
   p_relock_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (unlocked_i && bus_wr_i && bus_addr_i == KEY_OFS) |=> !unlocked_i);

   // R7: an all-zero write leaves pending bits alone (apart from hardware sets)
   p_zero_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_wr_i && bus_addr_i == PEND_OFS && bus_wdata_i[N_IRQ-1:0] == '0)
      |=> irq_o == ($past(irq_o) | $past(rise_i)));

   // R8: reserved fields of the routing register read zero
   p_reserved_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_addr_i == ROUTE_OFS) |-> (bus_rdata_o[31:9] == '0
                                     && bus_rdata_o[7:SEL_W] == '0));

   // R9: a synchronized edge always leaves its pending bit set
   p_hw_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rise_i != '0) |=> ((irq_o & $past(rise_i)) == $past(rise_i)));

endmodule

bind irq_collector irq_collector_chk #(
   .N_IRQ    (N_IRQ),
   .ADDR_W   (ADDR_W),
   .ROUTE_OFS(ROUTE_OFS),
   .PEND_OFS (PEND_OFS),
   .KEY_OFS  (KEY_OFS),
   .KEY2     (KEY2)
) chk_i (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .bus_wr_i   (bus_wr_i),
   .bus_addr_i (bus_addr_i),
   .bus_wdata_i(bus_wdata_i),
   .bus_rdata_o(bus_rdata_o),
   .irq_o      (irq_o),
   .nmi_o      (nmi_o),
   .rise_i     (hw_rise),
   .nmi_en_i   (nmi_en_q),
   .unlocked_i (unlocked)
);

// File: tb/irq_collector_tb_top.sv
module irq_collector_tb_top;

   localparam logic [7:0] A_ROUTE = 8'h80;
   localparam logic [7:0] A_PEND  = 8'h84;
   localparam logic [7:0] A_KEY   = 8'h88;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] per_irq = '0;
   logic [31:0] irq;
   logic        nmi;

   int checks = 0;
   int fails  = 0;

   // bench model
   logic [31:0] m_pend = '0;
   logic [4:0]  m_sel  = '0;
   logic        m_en   = 1'b0;
   int          m_key  = 0;

   always #4 clk = ~clk;

   irq_collector dut_i (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .bus_wr_i   (bus_wr),
      .bus_addr_i (bus_addr),
      .bus_wdata_i(bus_wdata),
      .bus_rdata_o(bus_rdata),
      .per_irq_i  (per_irq),
      .irq_o      (irq),
      .nmi_o      (nmi)
   );

   function automatic int key_step(int st, logic [7:0] b);
      case (st)
         0: return (b == 8'h59) ? 1 : 0;
         1: return (b == 8'h16) ? 2 : 0;
         2: return (b == 8'h88) ? 3 : 0;
         default: return 0;
      endcase
   endfunction

   function automatic logic [31:0] route_img(logic [4:0] s, logic e);
      return {23'd0, e, 3'd0, s};
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
      if (a == A_PEND) m_pend = m_pend ^ d;
      else if (a == A_ROUTE) begin
         m_sel = d[4:0];
         if (m_key == 3) m_en = d[8];
      end else if (a == A_KEY) m_key = key_step(m_key, d[7:0]);
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic unlock();
      wr(A_KEY, 32'h59); wr(A_KEY, 32'h16); wr(A_KEY, 32'h88);
   endtask

   task automatic check_regs(string req);
      logic [31:0] v;
      rd(A_PEND, v);  chk(req, v, m_pend);
      rd(A_ROUTE, v); chk(req, v, route_img(m_sel, m_en));
      rd(A_KEY, v);   chk(req, v, {31'd0, m_key == 3});
      chk(req, irq, m_pend);
   endtask

   initial begin
      #(8 * 150000);
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check_regs("R1");
      chk("R1 nmi", {31'd0, nmi}, 32'd0);

      // R7 flip rule
      wr(A_PEND, 32'h0000_00F0); check_regs("R7 set");
      wr(A_PEND, 32'h0000_0030); check_regs("R7 clear");
      wr(A_PEND, 32'h0000_0000); check_regs("R7 zero ignored");
      wr(A_PEND, 32'h0000_00C0); check_regs("R7 clear rest");

      // R4 and R8 while locked
      wr(A_ROUTE, 32'h0000_011F); check_regs("R4 locked enable");
      wr(A_ROUTE, 32'hFFFF_FFFF); check_regs("R8 reserved");

      // R5 unlock, enable, R6 relock
      unlock(); check_regs("R5 open");
      wr(A_ROUTE, 32'h0000_0105); check_regs("R5 enable write");
      wr(A_KEY, 32'h0000_0000); check_regs("R6 relock");
      wr(A_ROUTE, 32'h0000_0005); check_regs("R4 disable refused");
      wr(A_KEY, 32'h59); wr(A_KEY, 32'h00); wr(A_KEY, 32'h16); wr(A_KEY, 32'h88);
      check_regs("R6 wrong byte");
      wr(A_KEY, 32'h59); wr(A_KEY, 32'h16); wr(A_KEY, 32'h59);
      wr(A_KEY, 32'h16); wr(A_KEY, 32'h88);
      check_regs("R6 wrong byte no restart credit");
      if (m_key != 0) begin
         wr(A_KEY, 32'h0);
      end

      // R2 and R3: pulse line 5 with routing on sel 5
      @(negedge clk);
      per_irq[5] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R2 latency early", irq, 32'd0);
      chk("R3 nmi early", {31'd0, nmi}, 32'd0);
      @(negedge clk);
      chk("R2 set", irq, 32'h20);
      chk("R3 nmi follows", {31'd0, nmi}, 32'd1);
      m_pend = 32'h20;
      wr(A_PEND, 32'h20);
      repeat (5) @(negedge clk);
      check_regs("R2 level no reset");
      chk("R3 nmi level", {31'd0, nmi}, 32'd1);
      wr(A_ROUTE, 32'h0000_0006);
      @(negedge clk);
      chk("R3 selector move", {31'd0, nmi}, 32'd0);
      wr(A_ROUTE, 32'h0000_0005);
      @(negedge clk);
      chk("R3 selector back", {31'd0, nmi}, 32'd1);
      unlock();
      wr(A_ROUTE, 32'h0000_0005);
      wr(A_KEY, 32'h0);
      @(negedge clk);
      chk("R3 disabled", {31'd0, nmi}, 32'd0);
      check_regs("R3 disabled regs");

      // R9 set and clear meet in one cycle
      wr(A_PEND, 32'h20);
      per_irq[5] = 1'b0;
      repeat (4) @(negedge clk);
      per_irq[5] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = A_PEND; bus_wdata = 32'h20;
      @(negedge clk);
      bus_wr = 1'b0;
      chk("R9 set wins", irq, 32'h20);
      m_pend = 32'h20;
      wr(A_PEND, 32'h20);
      check_regs("R9 later clear");
      per_irq[5] = 1'b0;
      repeat (4) @(negedge clk);

      // random mix, peripheral lines quiet
      for (int it = 0; it < 400; it++) begin
         int op;
         op = int'($urandom_range(0, 5));
         case (op)
            0, 1: wr(A_PEND, $urandom());
            2: wr(A_ROUTE, $urandom());
            3: begin
               logic [7:0] kb;
               case ($urandom_range(0, 3))
                  0: kb = 8'h59;
                  1: kb = 8'h16;
                  2: kb = 8'h88;
                  default: kb = 8'($urandom());
               endcase
               wr(A_KEY, {24'($urandom()), kb});
            end
            4: unlock();
            default: wr(8'($urandom_range(0, 255)) | 8'h01, $urandom());
         endcase
         check_regs("R7 R4 R6 random");
         chk("R3 random quiet", {31'd0, nmi}, 32'd0);
      end

      rd(A_PEND, v);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule